// File: doc/BRIEF.md
# Latched Fault Shutdown Supervisor

This block sits between the analog protection comparators of a two-phase bridge motor driver and the bridge controllers. It watches a supply-undervoltage flag, an over-temperature flag and an over-current/sense-voltage flag, plus an active-low standby pin. From these it drives a global output enable for the bridges, an enable for the chopping oscillator, and one sticky status bit for each fault cause. All inputs arrive already synchronised to the block clock.

The temperature and current flags pass through a persistence filter. A flag counts only after it has been high for `QUAL` consecutive clock samples. A qualified fault latches the bridges off, and the latch holds after the comparator releases. The latch and its status bits clear only while the supply-undervoltage flag is high or the standby pin is low. Clearing wins over setting. If a fault is still present when the clear condition ends, it latches again at the first clock edge after the clear.

Top module: `fault_supervisor`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, all four outputs are 0 after that edge, and both filter histories are emptied.
- R2: A fault input counts as qualified only after `QUAL` (default 4) consecutive samples high. A pulse of `QUAL-1` samples leaves the flags and `drive_en` unchanged. A low sample restarts the count.
- R3: When `overtemp` is sampled high at edges k to k+QUAL-1, `thermal_flag` goes to 1 and `drive_en` goes to 0 at edge k+QUAL, provided no clear is active.
- R4: The same holds for `overcurrent` and `overcur_flag`, independently of the thermal path.
- R5: A set status bit stays 1, and `drive_en` stays 0, after its fault input returns low, for as long as no clear is active.
- R6: `standby_n` low at an edge makes `osc_en`, `drive_en` and both status bits 0 after that edge. `osc_en` follows `standby_n` with one edge of delay.
- R7: `por_active` high at an edge makes `drive_en` and both status bits 0 after that edge. It does not affect `osc_en`.
- R8: A clear beats a qualified fault. While the clear is active the status bits stay 0. When the clear ends with the fault still qualified, the bit sets at the first edge without the clear.
- R9: `drive_en` is 1 after an edge exactly when, at that edge, `standby_n` is 1, `por_active` is 0 and neither status bit is being set or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| por_active | input | 1 | Supply below its detect threshold, active high |
| overtemp | input | 1 | Junction over-temperature comparator, active high |
| overcurrent | input | 1 | Over-current / sense-voltage comparator, active high |
| standby_n | input | 1 | Standby pin, low puts the driver in standby |
| drive_en | output | 1 | Global enable for the bridge output stages |
| osc_en | output | 1 | Enable for the chopping oscillator |
| thermal_flag | output | 1 | Sticky cause bit: over-temperature shutdown |
| overcur_flag | output | 1 | Sticky cause bit: over-current shutdown |

## Verification
A fault held from sampling edge k shows up at edge k+QUAL, on both its status bit and `drive_en`. `standby_n` and `por_active` act on the outputs at the first edge that samples them. The bench drives inputs on falling edges. A behavioural model counts runs of high samples in integers and updates at each rising edge. All four outputs are compared with the model at every falling edge. Scenario checks at fixed falling edges test the boundaries by hand-derived values: a QUAL-1 glitch against a QUAL-long pulse, stickiness, and re-latching when the clear ends.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int NUM_FLT   = 2;
  localparam int FLT_THERM = 0;
  localparam int FLT_OVCUR = 1;
endpackage

// File: rtl/qual_filter.sv
module qual_filter #(
  parameter int QUAL = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic qual
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= '0;
    else if (!din)          run_cnt <= '0;
    else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
  end

  assign qual = (run_cnt == LIMIT);

  // R2: qualification implies the latest sample was high
  a_r2_qual_needs_input: assert property (@(posedge clk) disable iff (rst)
    qual |-> $past(din));
  // R2: a low sample drops qualification at once
  a_r2_low_restarts: assert property (@(posedge clk) disable iff (rst)
    !din |=> !qual);
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import fsup_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               por_active,
  input  logic               standby_n,
  input  logic [NUM_FLT-1:0] qual,
  output logic [NUM_FLT-1:0] flags,
  output logic               drive_en,
  output logic               osc_en
);
  logic               clear;
  logic [NUM_FLT-1:0] flags_nxt;

  assign clear = por_active | ~standby_n;

  for (genvar i = 0; i < NUM_FLT; i++) begin : g_bit
    assign flags_nxt[i] = clear ? 1'b0 : (flags[i] | qual[i]);

    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= flags_nxt[i];
    end

    // R5: a set bit holds while no clear is present
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !por_active && standby_n) |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en <= 1'b0;
      osc_en   <= 1'b0;
    end else begin
      drive_en <= standby_n & ~por_active & ~(|flags_nxt);
      osc_en   <= standby_n;
    end
  end

  // R3: bridges never enabled while a cause bit is set
  a_r3_off_with_fault: assert property (@(posedge clk) disable iff (rst)
    (|flags) |-> !drive_en);
  // R6: standby drops everything on the next edge
  a_r6_standby_off: assert property (@(posedge clk) disable iff (rst)
    !standby_n |=> (!osc_en && !drive_en && flags == '0));
  // R7: undervoltage holds outputs off and clears the latch
  a_r7_por_off: assert property (@(posedge clk) disable iff (rst)
    por_active |=> (!drive_en && flags == '0));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int QUAL = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic por_active,
  input  logic overtemp,
  input  logic overcurrent,
  input  logic standby_n,
  output logic drive_en,
  output logic osc_en,
  output logic thermal_flag,
  output logic overcur_flag
);
  logic [NUM_FLT-1:0] raw;
  logic [NUM_FLT-1:0] qual;
  logic [NUM_FLT-1:0] flags;

  assign raw[FLT_THERM] = overtemp;
  assign raw[FLT_OVCUR] = overcurrent;

  for (genvar i = 0; i < NUM_FLT; i++) begin : g_filt
    qual_filter #(.QUAL(QUAL)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw[i]),
      .qual(qual[i])
    );
  end

  fault_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .por_active(por_active),
    .standby_n (standby_n),
    .qual      (qual),
    .flags     (flags),
    .drive_en  (drive_en),
    .osc_en    (osc_en)
  );

  assign thermal_flag = flags[FLT_THERM];
  assign overcur_flag = flags[FLT_OVCUR];

  // R1: reset leaves every output low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (!drive_en && !osc_en && !thermal_flag && !overcur_flag));
endmodule

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  localparam int QUAL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por = 1'b0, ovt = 1'b0, ocp = 1'b0, stby = 1'b0;
  logic drive_en, osc_en, thermal_flag, overcur_flag;

  int checks = 0, fails = 0, cycles = 0;
  bit started = 0, done = 0;

  int  m_run_t = 0, m_run_o = 0;
  bit  m_th = 0, m_oc = 0, m_drv = 0, m_osc = 0;

  always #10 clk = ~clk;

  fault_supervisor #(.QUAL(QUAL)) u0 (
    .clk(clk), .rst(rst), .por_active(por), .overtemp(ovt),
    .overcurrent(ocp), .standby_n(stby), .drive_en(drive_en),
    .osc_en(osc_en), .thermal_flag(thermal_flag), .overcur_flag(overcur_flag)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: run lengths of high samples and sticky bits
  always @(posedge clk) begin
    bit clr, qt, qo;
    started = 1;
    if (rst) begin
      m_run_t = 0; m_run_o = 0; m_th = 0; m_oc = 0; m_drv = 0; m_osc = 0;
    end else begin
      clr = por || !stby;
      qt = (m_run_t >= QUAL);
      qo = (m_run_o >= QUAL);
      m_th = clr ? 1'b0 : (m_th || qt);
      m_oc = clr ? 1'b0 : (m_oc || qo);
      m_run_t = ovt ? (m_run_t < 1000 ? m_run_t + 1 : m_run_t) : 0;
      m_run_o = ocp ? (m_run_o < 1000 ? m_run_o + 1 : m_run_o) : 0;
      m_drv = stby && !por && !m_th && !m_oc;
      m_osc = stby;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R9 drive_en vs model", drive_en, m_drv);
      chk("R6 osc_en vs model", osc_en, m_osc);
      chk("R3 thermal_flag vs model", thermal_flag, m_th);
      chk("R4 overcur_flag vs model", overcur_flag, m_oc);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1 reset drive_en", drive_en, 1'b0);
    chk("R1 reset osc_en", osc_en, 1'b0);
    chk("R1 reset flags", thermal_flag | overcur_flag, 1'b0);
    rst = 0; stby = 1;
    step(1);
    chk("R9 enable after standby release", drive_en, 1'b1);
    chk("R6 osc follows standby", osc_en, 1'b1);
    // R2: glitch of QUAL-1 samples ignored
    ovt = 1; step(QUAL - 1); ovt = 0;
    step(4);
    chk("R2 short glitch no flag", thermal_flag, 1'b0);
    chk("R2 short glitch drive kept", drive_en, 1'b1);
    // R3: QUAL samples latch, due at edge k+QUAL
    ovt = 1; step(QUAL);
    chk("R3 not before k+QUAL", thermal_flag, 1'b0);
    ovt = 0; step(1);
    chk("R3 thermal set at k+QUAL", thermal_flag, 1'b1);
    chk("R3 drive off", drive_en, 1'b0);
    step(10);
    chk("R5 thermal sticky", thermal_flag, 1'b1);
    chk("R5 drive stays off", drive_en, 1'b0);
    // R6: standby clears
    stby = 0; step(1);
    chk("R6 standby clears thermal", thermal_flag, 1'b0);
    chk("R6 standby osc off", osc_en, 1'b0);
    stby = 1; step(2);
    chk("R9 drive back on", drive_en, 1'b1);
    // R4: over-current path
    ocp = 1; step(QUAL + 1);
    chk("R4 overcur set", overcur_flag, 1'b1);
    chk("R4 thermal untouched", thermal_flag, 1'b0);
    // R7/R8: por clears while fault persists
    por = 1; step(1);
    chk("R7 por clears overcur", overcur_flag, 1'b0);
    chk("R7 osc unaffected", osc_en, 1'b1);
    step(5);
    chk("R8 clear beats fault", overcur_flag, 1'b0);
    chk("R7 drive held off", drive_en, 1'b0);
    por = 0; step(1);
    chk("R8 relatch first edge", overcur_flag, 1'b1);
    chk("R8 drive off on relatch", drive_en, 1'b0);
    ocp = 0; stby = 0; step(1); stby = 1; step(2);
    chk("R9 final enable", drive_en, 1'b1);
    // R1: reset mid-run empties history
    ovt = 1; step(QUAL - 1); rst = 1; step(1); rst = 0; step(1);
    chk("R1 history cleared", thermal_flag, 1'b0);
    ovt = 0; step(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule